// File: doc/BRIEF.md
# Bus Error Capture Unit

This block keeps a record of the first bus transaction that fails, so that software can look at it later. Error detection happens elsewhere. The detecting logic presents a one-cycle error strobe together with the transaction's details: the 32-bit address, the 32-bit data, the byte enables and the bus command. It also gives two cause bits, one for a retry counter that ran out on a posted write and one for a master abort.

If reporting is enabled and no error is being held, the unit latches all of these details on the strobe and sets a sticky report flag. The report flag drives an interrupt request. While the flag is set, the unit ignores any further errors, so the first failure stays intact until software has dealt with it.

Software reaches the unit through a simple register port, which has one write strobe and one word select. It sees three readable words: a control/status word, the captured address and the captured data. Software re-arms the unit by writing a 1 to the report flag's bit.

Top module: `errlog_unit`

## Requirements
- R1: On a logged error, `addr_word` and `data_word` take the full error address and error data one cycle after the strobe. Writes to word selects 1, 2 and 3 change nothing, so these two words are read-only.
- R2: On a logged error, bits 31..24 of `status_word` take the byte enables in bits 31..28 and the bus command in bits 27..24.
- R3: On a logged error, bit 10 of `status_word` takes the retry-expiry cause bit.
- R4: On a logged error, bit 9 of `status_word` takes the master-abort cause bit.
- R5: An error is logged when `err_strobe` is high, the enable (bit 0) is 1 and the report flag (bit 8) is 0. From the next cycle, bit 8 reads 1.
- R6: A write with `reg_sel` = 0 loads bit 0 of `status_word` from `reg_wdata[0]`. While bit 0 is 0, strobes are not logged: every output keeps its value.
- R7: While bit 8 is 1, further strobes change no captured field, so the first error's details are kept.
- R8: A write with `reg_sel` = 0 and `reg_wdata[8]` = 1 clears bit 8 on the next cycle. A write with `reg_wdata[8]` = 0 leaves bit 8 as it was.
- R9: Bits 23..11 and 7..1 of `status_word` always read 0.
- R10: `irq` equals bit 8 of `status_word` in every cycle.
- R11: After reset every output reads 0, and reporting is disabled.
- R12: A strobe decides whether to log using the enable and flag values from before the cycle. If a clear write and a strobe fall in the same cycle, the strobe wins when the flag was 0, and the clear wins when the flag was 1. An enable write takes effect only from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_strobe | input | 1 | One-cycle error indication |
| err_addr | input | 32 | Address of the failing transaction |
| err_data | input | 32 | Data of the failing transaction |
| err_be | input | 4 | Byte enables of the failing transaction |
| err_cmd | input | 4 | Bus command of the failing transaction |
| err_retry_exp | input | 1 | Cause: retry counter expired on a posted write |
| err_mabort | input | 1 | Cause: master abort |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Word select (0 status, 1 address, 2 data) |
| reg_wdata | input | 32 | Register write data |
| status_word | output | 32 | Control/status word |
| addr_word | output | 32 | Captured address |
| data_word | output | 32 | Captured data |
| irq | output | 1 | Interrupt request, high while an error is held |

## Verification
Two functions can fall in the same cycle: a software write to the status word and an arriving error strobe. The bench drives both in one cycle in four combinations. The flag is either clear or already set, and the write clears the flag or changes the enable.

A scoreboard model judges each combination. It applies the rule of R12 using the pre-cycle enable and flag, and it compares the status, address, data and interrupt outputs on the following falling edge.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

  localparam int STAT_W   = 32;
  localparam int BE_W     = 4;
  localparam int CMD_W    = 4;
  localparam int DETAIL_W = BE_W + CMD_W;

  // field positions inside the status word (software decodes these)
  localparam int POS_EN     = 0;
  localparam int POS_FLAG   = 8;
  localparam int POS_MABORT = 9;
  localparam int POS_RETRY  = 10;
  localparam int POS_DETAIL = 24;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_ADDR   = 2'd1;
  localparam logic [1:0] SEL_DATA   = 2'd2;

  // bits that carry state; every other status bit must read zero
  localparam logic [STAT_W-1:0] LIVE_MASK =
      ({{(STAT_W-DETAIL_W){1'b0}}, {DETAIL_W{1'b1}}} << POS_DETAIL) |
      (STAT_W'(1) << POS_RETRY) | (STAT_W'(1) << POS_MABORT) |
      (STAT_W'(1) << POS_FLAG)  | (STAT_W'(1) << POS_EN);

  typedef struct packed {
    logic [DETAIL_W-1:0] detail;
    logic                retry;
    logic                mabort;
  } cause_t;

  // an error is taken only when enabled and nothing is being held
  function automatic logic log_allowed(input logic strobe, input logic en,
                                       input logic flag);
    return strobe && en && !flag;
  endfunction

  // next value of the sticky flag: a new capture wins over a clear
  function automatic logic flag_next(input logic flag, input logic take,
                                     input logic clr);
    if (take) return 1'b1;
    if (clr)  return 1'b0;
    return flag;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input cause_t c,
                                                    input logic flag,
                                                    input logic en);
    logic [STAT_W-1:0] w;
    w = '0;
    w[POS_DETAIL +: DETAIL_W] = c.detail;
    w[POS_RETRY]              = c.retry;
    w[POS_MABORT]             = c.mabort;
    w[POS_FLAG]               = flag;
    w[POS_EN]                 = en;
    return w;
  endfunction

endpackage

// File: rtl/errlog_ctrl.sv
module errlog_ctrl
  import errlog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_strobe,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic       wr_en_bit,
  input  logic       wr_clr_bit,
  output logic       en_q,
  output logic       flag_q,
  output logic       cap_fire,
  output logic       clr_hit,
  output logic       irq
);

  logic stat_wr;

  assign stat_wr  = reg_wr && (reg_sel == SEL_STATUS);
  assign clr_hit  = stat_wr && wr_clr_bit;
  assign cap_fire = log_allowed(err_strobe, en_q, flag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (stat_wr) en_q <= wr_en_bit;
      flag_q <= flag_next(flag_q, cap_fire, clr_hit);
      irq    <= flag_next(flag_q, cap_fire, clr_hit);
    end
  end

  assert_capture_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && en_q && !flag_q) |=> flag_q);

  assert_disabled_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && !en_q && !flag_q) |=> !flag_q);

  assert_clear_drops_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && reg_wr && reg_sel == SEL_STATUS && wr_clr_bit) |=> !flag_q);

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(reg_wr && reg_sel == SEL_STATUS && wr_clr_bit)) |=> flag_q);

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
  import errlog_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_fire,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [DATA_W-1:0] err_data,
  input  logic [BE_W-1:0]   err_be,
  input  logic [CMD_W-1:0]  err_cmd,
  input  logic              err_retry_exp,
  input  logic              err_mabort,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output cause_t            cause_q
);

  cause_t cause_d;

  always_comb begin
    cause_d.detail = {err_be, err_cmd};
    cause_d.retry  = err_retry_exp;
    cause_d.mabort = err_mabort;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      cause_q <= '0;
    end else if (cap_fire) begin
      addr_q  <= err_addr;
      data_q  <= err_data;
      cause_q <= cause_d;
    end
  end

  assert_capture_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (addr_q == $past(err_addr) && data_q == $past(err_data)));

  assert_capture_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cause_q.retry == $past(err_retry_exp) &&
                  cause_q.mabort == $past(err_mabort)));

endmodule

// File: rtl/errlog_pack.sv
module errlog_pack
  import errlog_pkg::*;
(
  input  cause_t            cause_q,
  input  logic              flag_q,
  input  logic              en_q,
  output logic [STAT_W-1:0] status_word
);

  assign status_word = pack_status(cause_q, flag_q, en_q);

  always_comb begin
    assert_unimpl_zero_R9: assert ((status_word & ~LIVE_MASK) == '0);
  end

endmodule

// File: rtl/errlog_unit.sv
module errlog_unit
  import errlog_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_strobe,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [DATA_W-1:0] err_data,
  input  logic [3:0]        err_be,
  input  logic [3:0]        err_cmd,
  input  logic              err_retry_exp,
  input  logic              err_mabort,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       status_word,
  output logic [ADDR_W-1:0] addr_word,
  output logic [DATA_W-1:0] data_word,
  output logic              irq
);

  logic   en_q;
  logic   flag_q;
  logic   cap_fire;
  logic   clr_hit;
  cause_t cause_q;

  errlog_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_strobe (err_strobe),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .wr_en_bit  (reg_wdata[POS_EN]),
    .wr_clr_bit (reg_wdata[POS_FLAG]),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .cap_fire   (cap_fire),
    .clr_hit    (clr_hit),
    .irq        (irq)
  );

  errlog_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_fire      (cap_fire),
    .err_addr      (err_addr),
    .err_data      (err_data),
    .err_be        (err_be),
    .err_cmd       (err_cmd),
    .err_retry_exp (err_retry_exp),
    .err_mabort    (err_mabort),
    .addr_q        (addr_word),
    .data_q        (data_word),
    .cause_q       (cause_q)
  );

  errlog_pack u_pack (
    .cause_q     (cause_q),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .status_word (status_word)
  );

  assert_irq_tracks_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == status_word[POS_FLAG]);

  assert_first_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[POS_FLAG] && !clr_hit) |=>
      ($stable(addr_word) && $stable(data_word) &&
       $stable(status_word[31:POS_MABORT])));

  assert_detail_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> status_word[31:24] == $past({err_be, err_cmd}));

endmodule

// File: tb/tb_errlog_unit.sv
module tb_errlog_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_strobe = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] err_data = '0;
  logic [3:0]  err_be = '0;
  logic [3:0]  err_cmd = '0;
  logic        err_retry_exp = 1'b0;
  logic        err_mabort = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status_word;
  logic [31:0] addr_word;
  logic [31:0] data_word;
  logic        irq;

  always #2.5 clk = ~clk;

  errlog_unit dut (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_addr(err_addr),
    .err_data(err_data), .err_be(err_be), .err_cmd(err_cmd),
    .err_retry_exp(err_retry_exp), .err_mabort(err_mabort), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .status_word(status_word),
    .addr_word(addr_word), .data_word(data_word), .irq(irq)
  );

  typedef struct {
    logic [31:0] st;
    logic [31:0] ad;
    logic [31:0] dt;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference model state
  bit       m_en, m_flag, m_retry, m_mab;
  bit [7:0] m_top;
  bit [31:0] m_addr, m_data;

  function automatic logic [31:0] model_status();
    logic [31:0] s;
    s = 32'h0;
    s[31:24] = m_top;
    s[10] = m_retry;
    s[9]  = m_mab;
    s[8]  = m_flag;
    s[0]  = m_en;
    return s;
  endfunction

  task automatic push_exp(input string req);
    exp_t e;
    e.st = model_status(); e.ad = m_addr; e.dt = m_data; e.req = req;
    exp_q.push_back(e);
  endtask

  // one cycle: optional error strobe and optional register write
  task automatic cycle(input bit strobe, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic [3:0] cmd,
                       input bit rty, input bit mab,
                       input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                       input string req);
    bit take, clr;
    @(negedge clk);
    err_strobe = strobe; err_addr = a; err_data = d; err_be = be; err_cmd = cmd;
    err_retry_exp = rty; err_mabort = mab;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    take = strobe && m_en && !m_flag;
    clr  = wr && sel == 2'd0 && wd[8];
    if (take) begin
      m_addr = a; m_data = d; m_top = {be, cmd}; m_retry = rty; m_mab = mab;
    end
    if (wr && sel == 2'd0) m_en = wd[0];
    m_flag = take ? 1'b1 : (clr ? 1'b0 : m_flag);
    push_exp(req);
  endtask

  task automatic err(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                     input logic [3:0] cmd, input bit rty, input bit mab, input string req);
    cycle(1, a, d, be, cmd, rty, mab, 0, 2'd0, 32'h0, req);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] wd, input string req);
    cycle(0, 32'h0, 32'h0, 4'h0, 4'h0, 0, 0, 1, sel, wd, req);
  endtask

  // monitor: compare one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (status_word !== e.st || addr_word !== e.ad || data_word !== e.dt ||
            irq !== e.st[8]) begin
          n_fail++;
          $display("FAIL %s: status=%h addr=%h data=%h irq=%b expected status=%h addr=%h data=%h irq=%b",
                   e.req, status_word, addr_word, data_word, irq, e.st, e.ad, e.dt, e.st[8]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    push_exp("R11 reset");
    // R6: disabled -> strobe ignored
    err(32'hDEAD0001, 32'h11110001, 4'hF, 4'h7, 1, 0, "R6 disabled strobe");
    // R6: enable
    wreg(2'd0, 32'h0000_0001, "R6 enable write");
    // R1 R2 R3: capture with retry cause
    err(32'hA5A5_1234, 32'hCAFE_F00D, 4'h3, 4'hB, 1, 0, "R1 R2 R3 R5 capture retry");
    // R7: second error ignored
    err(32'h0BAD_0BAD, 32'h2222_2222, 4'hC, 4'h2, 0, 1, "R7 second error kept first");
    // R1: writes to address/data selects ignored
    wreg(2'd1, 32'hFFFF_FFFF, "R1 addr word read-only");
    wreg(2'd2, 32'hFFFF_FFFF, "R1 data word read-only");
    wreg(2'd3, 32'hFFFF_FFFF, "R1 unused select");
    // R8: writing 0 to bit 8 keeps flag
    wreg(2'd0, 32'h0000_0001, "R8 write zero keeps flag");
    // R8: clear
    wreg(2'd0, 32'h0000_0101, "R8 clear flag");
    // R4: master abort cause
    err(32'h1357_9BDF, 32'h0246_8ACE, 4'h1, 4'h6, 0, 1, "R4 capture master abort");
    // R12: flag set + clear + strobe same cycle -> clear wins
    cycle(1, 32'h7777_7777, 32'h8888_8888, 4'h8, 4'h1, 1, 1, 1, 2'd0, 32'h0000_0101,
          "R12 clear wins over held flag");
    // R12: flag clear + clear write + strobe -> capture wins
    cycle(1, 32'h4444_0000, 32'h5555_0000, 4'hA, 4'h5, 1, 1, 1, 2'd0, 32'h0000_0101,
          "R12 capture wins when flag clear");
    wreg(2'd0, 32'h0000_0101, "R8 clear again");
    // R12: disable written with strobe -> old enable still used
    cycle(1, 32'h6666_6666, 32'h9999_9999, 4'h5, 4'hE, 0, 0, 1, 2'd0, 32'h0000_0000,
          "R12 enable write late");
    wreg(2'd0, 32'h0000_0100, "R8 clear while disabled");
    // R12: enable written with strobe -> not logged this cycle
    cycle(1, 32'h1212_1212, 32'h3434_3434, 4'hF, 4'hF, 1, 0, 1, 2'd0, 32'h0000_0001,
          "R12 enable not yet active");
    // R9 R10: all-ones stimulus, unimplemented bits stay zero
    err(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'hF, 4'hF, 1, 1, "R9 R10 all ones capture");
    wreg(2'd0, 32'hFFFF_FFFF, "R9 all ones write");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule